// File: doc/BRIEF.md
# Speculative Memory-Ordering Controller

This block decides, cycle by cycle, when a core leaves conventional in-order retirement and runs past a memory-ordering constraint under a register checkpoint. Each consistency model has its own trigger. The block asks for a checkpoint when the trigger fires. It releases the speculation in a single cycle as soon as no store is still outstanding. If a remote coherence request hits speculative state, it unwinds the speculation through a fixed sequence of flash operations.

Violation handling has an optional mode. Instead of aborting at once, the controller holds the conflicting external request for a bounded window. This gives the store buffer time to drain so the speculation can commit rather than roll back. Only one checkpoint can be live at a time. After an abort, the core must retire at least one instruction the ordinary way before a new checkpoint may be taken.

Top module: `spec_order_ctrl`

## Requirements
- R1: With `model_sel` 0 (strict ordering) or 3 (treated the same), `take_ckpt` rises in the cycle a load is ready to retire while `sb_empty` is low and the controller is idle.
- R2: With `model_sel` 1 (stores ordered, loads may pass), a store or atomic ready to retire while `sb_empty` is low raises `take_ckpt`. A load does not.
- R3: With `model_sel` 2 (relaxed), `take_ckpt` rises for a fence while `sb_empty` is low, or for an atomic while `atomic_miss` is high. A plain store does not trigger.
- R4: While `spec_active` is high, a fence retires without `retire_stall`. `commit` and `spec_bits_clear` pulse in the same cycle `sb_empty` is high (subject to R11), and `spec_active` drops on the next cycle.
- R5: A `force_commit` seen while speculating makes `retire_stall` high from the next cycle until the commit, which happens in the first cycle `sb_empty` is high.
- R6: When `cov_en` is 1, a violation asserts `defer_req` from that cycle on. If `sb_empty` rises inside the window, `commit` is issued instead of an abort.
- R7: With `cov_en` 1, a deferral window lasts exactly `DEFER_LIMIT` cycles of `defer_req`. In the cycle after the last one, the abort decision is taken if the store buffer still holds data.
- R8: When `cov_en` is 0, a violation while speculating starts the abort sequence on the next cycle and never raises `defer_req`.
- R9: An abort runs as three single-cycle steps, in this order, with `retire_stall` high throughout. First `pipe_flush` with `sb_spec_inval`. Then `cache_cond_inval` with `spec_bits_clear`. Then `ckpt_restore`.
- R10: After `ckpt_restore`, no checkpoint is taken until one instruction has retired without speculation. Until then a triggering instruction is held by `retire_stall`.
- R11: An atomic retiring under speculation, or starting it, blocks `commit` in its own cycle and in the following cycle, so both halves share one speculation.
- R12: During reset every output is low.
- R13: Further violations during an open deferral window neither restart nor extend it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| model_sel | input | 2 | Consistency model: 0 strict, 1 store-ordered, 2 relaxed, 3 as 0 |
| cov_en | input | 1 | Enable bounded deferral of violating requests |
| rt_load | input | 1 | Load ready to retire |
| rt_store | input | 1 | Store ready to retire |
| rt_atomic | input | 1 | Atomic read-modify-write ready to retire |
| rt_fence | input | 1 | Fence ready to retire |
| atomic_miss | input | 1 | Retiring atomic would wait on a store miss to its block |
| sb_empty | input | 1 | Store buffer holds no outstanding stores |
| violation | input | 1 | External request hit speculatively accessed state |
| force_commit | input | 1 | Request to end speculation (e.g. overflow eviction) |
| take_ckpt | output | 1 | Capture register checkpoint, speculation starts |
| commit | output | 1 | Speculation committed this cycle |
| spec_active | output | 1 | Speculation in flight |
| defer_req | output | 1 | Hold the conflicting external request |
| retire_stall | output | 1 | Block retirement this cycle |
| pipe_flush | output | 1 | Abort step 1: flush pipeline |
| sb_spec_inval | output | 1 | Abort step 1: drop speculative store-buffer entries |
| cache_cond_inval | output | 1 | Abort step 2: invalidate speculatively written lines |
| spec_bits_clear | output | 1 | Flash-clear speculative access bits (commit or abort step 2) |
| ckpt_restore | output | 1 | Abort step 3: restore register checkpoint |

## Verification
The properties assume that `cov_en` stays constant while a speculation is open. They also assume that `sb_empty` only reports drained state, so a commit never races stores the block cannot see. The stimulus changes `cov_en` and `model_sel` only while the controller is idle. It raises `violation` only as short pulses inside a speculation, and the reference model follows every combination it applies. The long-window scenario holds the store buffer non-empty for the whole default window, so the deferral bound is reached rather than assumed.

// File: rtl/spec_order_pkg.sv
package spec_order_pkg;

  typedef enum logic [1:0] {
    MDL_STRICT  = 2'd0,
    MDL_STORDER = 2'd1,
    MDL_RELAXED = 2'd2,
    MDL_RSVD    = 2'd3
  } model_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SPEC   = 3'd1,
    ST_AB_SB  = 3'd2,
    ST_AB_L1  = 3'd3,
    ST_AB_RST = 3'd4
  } ctl_state_e;

endpackage

// File: rtl/spec_trigger.sv
module spec_trigger
  import spec_order_pkg::*;
(
  input  logic [1:0] model_sel,
  input  logic       rt_load,
  input  logic       rt_store,
  input  logic       rt_atomic,
  input  logic       rt_fence,
  input  logic       atomic_miss,
  input  logic       sb_empty,
  output logic       trig
);

  logic sb_busy;
  assign sb_busy = ~sb_empty;

  always_comb begin
    unique case (model_e'(model_sel))
      MDL_STORDER: trig = (rt_store | rt_atomic) & sb_busy;
      MDL_RELAXED: trig = (rt_fence & sb_busy) | (rt_atomic & atomic_miss);
      default:     trig = rt_load & sb_busy;
    endcase
  end

endmodule

// File: rtl/spec_defer_timer.sv
module spec_defer_timer #(
  parameter int LIMIT = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clear,
  output logic active,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(LIMIT);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic          act_q, act_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd_en;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (clear) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else if (start) begin
      act_d = 1'b1;
      cnt_d = CNT_ONE;
    end else if (act_q && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + CNT_ONE;
    end
  end

  assign upd_en = clear | start | act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (upd_en) begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign active  = act_q;
  assign expired = act_q & (cnt_q == CNT_MAX);

endmodule

// File: rtl/spec_order_ctrl.sv
module spec_order_ctrl
  import spec_order_pkg::*;
#(
  parameter int DEFER_LIMIT = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] model_sel,
  input  logic       cov_en,
  input  logic       rt_load,
  input  logic       rt_store,
  input  logic       rt_atomic,
  input  logic       rt_fence,
  input  logic       atomic_miss,
  input  logic       sb_empty,
  input  logic       violation,
  input  logic       force_commit,
  output logic       take_ckpt,
  output logic       commit,
  output logic       spec_active,
  output logic       defer_req,
  output logic       retire_stall,
  output logic       pipe_flush,
  output logic       sb_spec_inval,
  output logic       cache_cond_inval,
  output logic       spec_bits_clear,
  output logic       ckpt_restore
);

  ctl_state_e st_q, st_d;
  logic forced_q, forced_d;
  logic rmw_q, rmw_d;
  logic cool_q, cool_d;

  logic trig, in_idle, in_spec, aborting, ev_any, atom_ret;
  logic new_defer, abort_go, tmr_active, tmr_expired, tmr_clear;

  spec_trigger u_trig (
    .model_sel   (model_sel),
    .rt_load     (rt_load),
    .rt_store    (rt_store),
    .rt_atomic   (rt_atomic),
    .rt_fence    (rt_fence),
    .atomic_miss (atomic_miss),
    .sb_empty    (sb_empty),
    .trig        (trig)
  );

  spec_defer_timer #(.LIMIT(DEFER_LIMIT)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (new_defer),
    .clear   (tmr_clear),
    .active  (tmr_active),
    .expired (tmr_expired)
  );

  assign in_idle  = (st_q == ST_IDLE);
  assign in_spec  = (st_q == ST_SPEC);
  assign aborting = (st_q == ST_AB_SB) | (st_q == ST_AB_L1) | (st_q == ST_AB_RST);
  assign ev_any   = rt_load | rt_store | rt_atomic | rt_fence;

  assign retire_stall = (in_idle & cool_q & trig) | (in_spec & forced_q) | aborting;
  assign atom_ret     = rt_atomic & ~retire_stall;

  assign take_ckpt = in_idle & ~cool_q & trig;
  assign commit    = in_spec & sb_empty & ~rmw_q & ~atom_ret;
  assign new_defer = in_spec & ~commit & violation & cov_en & ~tmr_active;
  assign abort_go  = in_spec & ~commit &
                     ((violation & ~cov_en & ~tmr_active) | tmr_expired);
  assign tmr_clear = commit | abort_go;
  assign defer_req = new_defer | (tmr_active & ~tmr_expired);

  assign spec_active      = in_spec;
  assign pipe_flush       = (st_q == ST_AB_SB);
  assign sb_spec_inval    = (st_q == ST_AB_SB);
  assign cache_cond_inval = (st_q == ST_AB_L1);
  assign spec_bits_clear  = commit | (st_q == ST_AB_L1);
  assign ckpt_restore     = (st_q == ST_AB_RST);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (take_ckpt) st_d = ST_SPEC;
      ST_SPEC: begin
        if (commit)        st_d = ST_IDLE;
        else if (abort_go) st_d = ST_AB_SB;
      end
      ST_AB_SB:  st_d = ST_AB_L1;
      ST_AB_L1:  st_d = ST_AB_RST;
      ST_AB_RST: st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    forced_d = forced_q;
    if (commit | abort_go)        forced_d = 1'b0;
    else if (in_spec & force_commit) forced_d = 1'b1;

    rmw_d = (take_ckpt & rt_atomic) | (in_spec & atom_ret);

    cool_d = cool_q;
    if (st_q == ST_AB_RST)                   cool_d = 1'b1;
    else if (in_idle & ev_any & ~retire_stall) cool_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      forced_q <= 1'b0;
      rmw_q    <= 1'b0;
      cool_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      forced_q <= forced_d;
      rmw_q    <= rmw_d;
      cool_q   <= cool_d;
    end
  end

endmodule

// File: rtl/spec_order_chk.sv
module spec_order_chk #(
  parameter int DEFER_LIMIT = 4000
) (
  input logic clk,
  input logic rst_n,
  input logic cov_en,
  input logic rt_atomic,
  input logic sb_empty,
  input logic force_commit,
  input logic take_ckpt,
  input logic commit,
  input logic spec_active,
  input logic defer_req,
  input logic retire_stall,
  input logic sb_spec_inval,
  input logic cache_cond_inval,
  input logic ckpt_restore
);

  localparam int DW = $clog2(DEFER_LIMIT + 2);
  localparam logic [DW-1:0] D_MAX = DW'(DEFER_LIMIT + 1);

  logic [DW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_q <= '0;
    else if (!defer_req)     run_q <= '0;
    else if (run_q != D_MAX) run_q <= run_q + DW'(1);
  end

  AST_ABORT_STEP1: assert property (@(posedge clk) disable iff (!rst_n)
    sb_spec_inval |=> cache_cond_inval); // R9
  AST_ABORT_STEP2: assert property (@(posedge clk) disable iff (!rst_n)
    cache_cond_inval |=> ckpt_restore); // R9
  AST_ABORT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_spec_inval | cache_cond_inval | ckpt_restore) |-> retire_stall); // R9
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_ckpt, commit, sb_spec_inval, cache_cond_inval, ckpt_restore})); // R9
  AST_COMMIT_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> sb_empty); // R4
  AST_DEFER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < D_MAX); // R7
  AST_NO_DEFER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    defer_req |-> cov_en); // R8
  AST_COOLDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_restore |=> !take_ckpt); // R10
  AST_RMW_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ckpt & rt_atomic) |=> !commit); // R11
  AST_FORCE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_active & force_commit & !sb_empty) |=> retire_stall); // R5

endmodule

bind spec_order_ctrl spec_order_chk #(.DEFER_LIMIT(DEFER_LIMIT)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .cov_en           (cov_en),
  .rt_atomic        (rt_atomic),
  .sb_empty         (sb_empty),
  .force_commit     (force_commit),
  .take_ckpt        (take_ckpt),
  .commit           (commit),
  .spec_active      (spec_active),
  .defer_req        (defer_req),
  .retire_stall     (retire_stall),
  .sb_spec_inval    (sb_spec_inval),
  .cache_cond_inval (cache_cond_inval),
  .ckpt_restore     (ckpt_restore)
);

// File: tb/tb_spec_order_ctrl.sv
module tb_spec_order_ctrl;

  localparam int LIM = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] model_sel = 2'd0;
  logic cov_en = 1'b0, rt_load = 1'b0, rt_store = 1'b0, rt_atomic = 1'b0, rt_fence = 1'b0;
  logic atomic_miss = 1'b0, sb_empty = 1'b1, violation = 1'b0, force_commit = 1'b0;
  logic take_ckpt, commit, spec_active, defer_req, retire_stall, pipe_flush;
  logic sb_spec_inval, cache_cond_inval, spec_bits_clear, ckpt_restore;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  // reference model state
  int  ms = 0;
  bit  mforced = 0, mrmw = 0, mcool = 0, mdact = 0;
  int  mdcnt = 0;
  // snapshot of DUT outputs from the last settled sample
  bit  sn_take, sn_commit, sn_defer, sn_stall, sn_sbinv, sn_restore, sn_active;
  int  dcount = 0;
  bit  saw_abort = 0;

  always #10 clk = ~clk;

  spec_order_ctrl dut (
    .clk(clk), .rst_n(rst_n), .model_sel(model_sel), .cov_en(cov_en),
    .rt_load(rt_load), .rt_store(rt_store), .rt_atomic(rt_atomic), .rt_fence(rt_fence),
    .atomic_miss(atomic_miss), .sb_empty(sb_empty), .violation(violation),
    .force_commit(force_commit), .take_ckpt(take_ckpt), .commit(commit),
    .spec_active(spec_active), .defer_req(defer_req), .retire_stall(retire_stall),
    .pipe_flush(pipe_flush), .sb_spec_inval(sb_spec_inval),
    .cache_cond_inval(cache_cond_inval), .spec_bits_clear(spec_bits_clear),
    .ckpt_restore(ckpt_restore)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp(input logic d, input bit m, input string tag);
    chk(d === m, tag, int'(d), int'(m));
  endtask

  // settle, compare against the model, then advance one clock
  task automatic tick();
    bit idle, spec, ab, trig, stall, atr, take, com, expd, nd, abg, dfr, anyev;
    #8;
    idle = (ms == 0); spec = (ms == 1); ab = (ms >= 2);
    case (model_sel)
      2'd1:    trig = (rt_store || rt_atomic) && !sb_empty;
      2'd2:    trig = (rt_fence && !sb_empty) || (rt_atomic && atomic_miss);
      default: trig = rt_load && !sb_empty;
    endcase
    anyev = rt_load || rt_store || rt_atomic || rt_fence;
    stall = (idle && mcool && trig) || (spec && mforced) || ab;
    atr   = rt_atomic && !stall;
    take  = idle && !mcool && trig;
    com   = spec && sb_empty && !mrmw && !atr;
    expd  = mdact && (mdcnt == LIM);
    nd    = spec && !com && violation && cov_en && !mdact;
    abg   = spec && !com && ((violation && !cov_en && !mdact) || expd);
    dfr   = nd || (mdact && !expd);

    cmp(take_ckpt, take, "R1 take_ckpt");
    cmp(commit, com, "R4 commit");
    cmp(spec_active, spec, "R4 spec_active");
    cmp(defer_req, dfr, "R6 defer_req");
    cmp(retire_stall, stall, "R5 retire_stall");
    cmp(pipe_flush, ms == 2, "R9 pipe_flush");
    cmp(sb_spec_inval, ms == 2, "R9 sb_spec_inval");
    cmp(cache_cond_inval, ms == 3, "R9 cache_cond_inval");
    cmp(spec_bits_clear, com || ms == 3, "R9 spec_bits_clear");
    cmp(ckpt_restore, ms == 4, "R9 ckpt_restore");

    sn_take = take_ckpt; sn_commit = commit; sn_defer = defer_req; sn_stall = retire_stall;
    sn_sbinv = sb_spec_inval; sn_restore = ckpt_restore; sn_active = spec_active;
    if (defer_req) dcount++;
    if (sb_spec_inval) saw_abort = 1;

    @(posedge clk);
    #1;
    if (com || abg) begin mdact = 0; mdcnt = 0; end
    else if (nd) begin mdact = 1; mdcnt = 1; end
    else if (mdact && mdcnt != LIM) mdcnt++;
    mrmw = (take && rt_atomic) || (spec && atr);
    if (com || abg) mforced = 0; else if (spec && force_commit) mforced = 1;
    if (ms == 4) mcool = 1; else if (idle && anyev && !stall) mcool = 0;
    case (ms)
      0: if (take) ms = 1;
      1: if (com) ms = 0; else if (abg) ms = 2;
      2: ms = 3;
      3: ms = 4;
      default: ms = 0;
    endcase
  endtask

  task automatic quiet();
    rt_load = 0; rt_store = 0; rt_atomic = 0; rt_fence = 0;
    atomic_miss = 0; violation = 0; force_commit = 0; sb_empty = 1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    // R12: reset state
    repeat (2) @(posedge clk);
    #8;
    chk({take_ckpt, commit, spec_active, defer_req, retire_stall, pipe_flush,
         sb_spec_inval, cache_cond_inval, spec_bits_clear, ckpt_restore} == 10'd0,
        "R12 outputs in reset", int'(retire_stall), 0);
    @(posedge clk); #1;
    rst_n = 1;
    tick();

    // R1: strict model, load over pending stores
    model_sel = 2'd0; sb_empty = 0; rt_load = 1; tick();
    chk(sn_take, "R1 load triggers", sn_take, 1);
    rt_load = 0; tick(); tick();
    sb_empty = 1; tick();
    chk(sn_commit, "R4 commit on drain", sn_commit, 1);
    tick();
    chk(!sn_active, "R4 idle after commit", sn_active, 0);
    // R1: code 3 behaves as strict
    model_sel = 2'd3; sb_empty = 0; rt_load = 1; tick();
    chk(sn_take, "R1 code 3 load triggers", sn_take, 1);
    quiet(); tick(); tick();

    // R2: store-ordered model
    model_sel = 2'd1; sb_empty = 0; rt_load = 1; tick();
    chk(!sn_take, "R2 load no trigger", sn_take, 0);
    rt_load = 0; rt_store = 1; tick();
    chk(sn_take, "R2 store triggers", sn_take, 1);
    rt_store = 0; rt_fence = 1; tick();
    chk(!sn_stall, "R4 fence retires freely", sn_stall, 0);
    quiet(); tick(); tick();

    // R3: relaxed model
    model_sel = 2'd2; sb_empty = 0; rt_store = 1; tick();
    chk(!sn_take, "R3 store no trigger", sn_take, 0);
    rt_store = 0; rt_fence = 1; tick();
    chk(sn_take, "R3 fence triggers", sn_take, 1);
    quiet(); tick(); tick();
    // R3 + R11: atomic stalled on a miss, store buffer already empty
    rt_atomic = 1; atomic_miss = 1; tick();
    chk(sn_take, "R3 atomic miss triggers", sn_take, 1);
    quiet(); tick();
    chk(!sn_commit, "R11 no commit after atomic", sn_commit, 0);
    tick();
    chk(sn_commit, "R11 commit one cycle later", sn_commit, 1);
    tick();

    // R5: force commit waits for drain with retirement stalled
    model_sel = 2'd1; sb_empty = 0; rt_store = 1; tick();
    rt_store = 0; force_commit = 1; tick();
    force_commit = 0; rt_load = 1; tick();
    chk(sn_stall, "R5 stall while forced", sn_stall, 1);
    tick();
    sb_empty = 1; tick();
    chk(sn_commit, "R5 commit after drain", sn_commit, 1);
    quiet(); tick(); tick();

    // R8, R9, R10: immediate abort then cooldown
    model_sel = 2'd0; cov_en = 0; sb_empty = 0; rt_load = 1; tick();
    rt_load = 0; violation = 1; tick();
    chk(!sn_defer, "R8 no deferral", sn_defer, 0);
    violation = 0; tick();
    chk(sn_sbinv, "R8 abort next cycle", sn_sbinv, 1);
    tick(); tick();
    chk(sn_restore, "R9 restore third step", sn_restore, 1);
    rt_load = 1; tick();
    chk(!sn_take && sn_stall, "R10 held after abort", sn_take, 0);
    tick();
    sb_empty = 1; tick();
    chk(!sn_stall, "R10 plain retire", sn_stall, 0);
    sb_empty = 0; tick();
    chk(sn_take, "R10 speculation allowed again", sn_take, 1);
    quiet(); tick(); tick();

    // R6: deferral ends in commit
    cov_en = 1; sb_empty = 0; rt_load = 1; tick();
    rt_load = 0; violation = 1; tick();
    chk(sn_defer, "R6 defer on violation", sn_defer, 1);
    violation = 0;
    for (int i = 0; i < 100; i++) tick();
    chk(sn_defer, "R6 still deferring", sn_defer, 1);
    sb_empty = 1; tick();
    chk(sn_commit, "R6 commit within window", sn_commit, 1);
    tick();
    chk(!sn_defer, "R6 request released", sn_defer, 0);

    // R7, R13: full window, second violation ignored
    sb_empty = 0; rt_load = 1; tick();
    rt_load = 0; dcount = 0; saw_abort = 0;
    violation = 1; tick();
    violation = 0;
    for (int i = 0; i < 9; i++) tick();
    violation = 1; tick();
    violation = 0;
    for (int i = 0; i < LIM + 20 && !saw_abort; i++) tick();
    chk(dcount == LIM, "R13 window not restarted", dcount, LIM);
    chk(saw_abort, "R7 abort after window", saw_abort, 1);
    quiet(); tick(); tick(); tick();
    rt_store = 1; tick();
    quiet(); tick();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule